// File: doc/BRIEF.md
# Local-Bus to Host-Port Bridge

This block is the glue between the local bus of a PCI bridge chip and the host port of a DSP on a shared board bus. The host CPU requests the shared bus with a hold request. The bridge first takes the bus away from the DSP by withdrawing the DSP's bus-ownership request. It waits until the DSP acknowledges the release, and only then grants the local bus. The host has fixed priority over the DSP.

Once the grant is given, an address strobe from the local bus starts a transfer. The bridge latches the address and decodes it against the host-port region. It takes write data one clock later. It then drives the host-port chip select, strobe, direction and select lines until the host port reports ready, or until a bounded wait expires. Completion is signalled to the local bus as a one-cycle active-low ready, with read data registered alongside it. Addresses outside the region complete without touching the host port. The host-port interrupt is passed straight through to the local bus.

Top module: `lb_hpi_bridge`

## Requirements
- R1: While the local-bus hold request is high, the DSP ownership request output is low from the clock edge after it is first seen high.
- R2: The local-bus hold acknowledge rises only at a clock edge at which the hold request is high and both the DSP ownership request and the DSP ownership acknowledge are low.
- R3: At the clock edge after the local-bus hold request is low, the hold acknowledge is low and the DSP ownership request is high.
- R4: After reset, the hold acknowledge is low, the DSP ownership request is high, chip select, strobe and local ready (all active low) are high, and the timeout flag is low.
- R5: An address strobe (active low) sampled while the bridge is idle and the hold acknowledge is high starts a transfer and latches the address and the direction (write = 1). An address strobe sampled without the acknowledge is ignored: no chip select and no ready follow.
- R6: Write data is sampled at the clock edge after the address strobe and is driven on the host-port data output while the strobe is low. The host-port read/not-write line is low for writes.
- R7: An address whose bits [15:12] equal 0xA lies in the host-port region. For such an access, the host-port chip select is low from the cycle after the address strobe until the strobe ends. For any other address, it never goes low.
- R8: During an access, the host-port half-word select equals latched address bit 2 and the two-bit register select equals latched address bits [4:3].
- R9: The host-port strobe stays low until the host-port ready is sampled high. Local ready is then low for exactly one cycle, in the next cycle, and the strobe lasts latency+1 cycles when ready is raised after latency cycles of strobe.
- R10: If ready is not sampled within TIMEOUT strobe cycles (default 8), the strobe ends after exactly TIMEOUT cycles. Local ready is still returned, read data is zero, and a sticky timeout flag is set that only reset clears. Ready seen in the last allowed cycle is not a timeout.
- R11: Read data from the host port is registered at the edge where ready is sampled, and is presented on the local read data while local ready is low.
- R12: An access outside the region returns local ready after one wait state: the ready is low in the second cycle after the address strobe cycle.
- R13: The local-bus interrupt output follows the host-port interrupt input (both active low) without a clock delay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for both sides |
| rst_n | input | 1 | Asynchronous active-low reset |
| lb_hold_req | input | 1 | Local-bus request for the shared bus |
| lb_hold_ack | output | 1 | Local-bus grant of the shared bus |
| dsp_own_req | output | 1 | Ownership request to the DSP (high lets the DSP own the bus) |
| dsp_own_ack | input | 1 | DSP acknowledge that it owns the bus |
| lb_ads_n | input | 1 | Local address strobe, active low |
| lb_addr | input | 16 | Local address |
| lb_wr | input | 1 | Direction, 1 = write |
| lb_wdata | input | 32 | Local write data |
| lb_rdata | output | 32 | Local read data |
| lb_ready_n | output | 1 | Local transfer ready, active low |
| lb_int_n | output | 1 | Interrupt to the local bus, active low |
| hp_cs_n | output | 1 | Host-port chip select, active low |
| hp_strobe_n | output | 1 | Host-port strobe, active low |
| hp_rnw | output | 1 | Host-port read/not-write |
| hp_hwsel | output | 1 | Host-port half-word select |
| hp_regsel | output | 2 | Host-port register select |
| hp_dout | output | 32 | Data to the host port |
| hp_din | input | 32 | Data from the host port |
| hp_rdy | input | 1 | Host-port ready, active high |
| hp_int_n | input | 1 | Host-port interrupt, active low |
| tmo_err | output | 1 | Sticky timeout flag |

## Verification
The hardest corner to reach is the edge where host-port ready arrives in the very cycle the timeout count runs out. Ready must win there: no timeout flag and real data. The bench reaches it by counting strobe cycles at the ports and raising ready exactly TIMEOUT-1 cycles after the strobe falls. A second hard case is a grant delayed by a DSP that still holds the bus. A small DSP model in the bench mirrors the ownership request into the acknowledge one clock late, so the two-stage release can be seen taking an extra cycle.

// File: rtl/lhb_pkg.sv
package lhb_pkg;

  typedef enum logic [1:0] {
    XS_IDLE = 2'd0,
    XS_CAPT = 2'd1,
    XS_STRB = 2'd2,
    XS_DONE = 2'd3
  } xfer_state_e;

  typedef struct packed {
    logic       hwsel;
    logic [1:0] regsel;
  } hp_sel_t;

  // host-port selects come from local address bits [4:2]
  function automatic hp_sel_t sel_from_addr(input logic [4:0] low);
    hp_sel_t s;
    s.hwsel  = low[2];
    s.regsel = low[4:3];
    return s;
  endfunction

endpackage

// File: rtl/lhb_hold_arb.sv
module lhb_hold_arb (
  input  logic clk,
  input  logic rst_n,
  input  logic lb_hold_req,
  input  logic dsp_own_ack,
  output logic dsp_own_req,
  output logic lb_hold_ack,
  output logic grant_evt
);

  assign grant_evt = lb_hold_req && !dsp_own_req && !dsp_own_ack && !lb_hold_ack;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dsp_own_req <= 1'b1;
      lb_hold_ack <= 1'b0;
    end else if (!lb_hold_req) begin
      lb_hold_ack <= 1'b0;
      dsp_own_req <= 1'b1;
    end else begin
      dsp_own_req <= 1'b0;
      if (grant_evt) lb_hold_ack <= 1'b1;
    end
  end

endmodule

// File: rtl/lhb_decode.sv
module lhb_decode #(
  parameter int          AW          = 16,
  parameter int          REGION_LSB  = 12,
  parameter logic [15:0] REGION_BASE = 16'hA000
) (
  input  logic [AW-1:0]       addr,
  output logic                hit,
  output lhb_pkg::hp_sel_t    sel
);

  localparam int RW = AW - REGION_LSB;

  function automatic logic region_match(input logic [AW-1:0] a);
    logic [AW-1:0] base;
    base = AW'(REGION_BASE);
    return a[AW-1:REGION_LSB] == base[AW-1:REGION_LSB];
  endfunction

  logic [RW-1:0] unused_w;
  assign unused_w = '0;
  assign hit = region_match(addr);
  assign sel = lhb_pkg::sel_from_addr(addr[4:0]);

endmodule

// File: rtl/lhb_xfer.sv
module lhb_xfer #(
  parameter int AW      = 16,
  parameter int DW      = 32,
  parameter int TIMEOUT = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          granted,
  input  logic          ads_n,
  input  logic [AW-1:0] addr,
  input  logic          wr,
  input  logic [DW-1:0] wdata,
  input  logic [DW-1:0] hp_din,
  input  logic          hp_rdy,
  input  logic          hit,
  output logic [AW-1:0] addr_q,
  output logic          hp_cs_n,
  output logic          hp_strobe_n,
  output logic          hp_rnw,
  output logic [DW-1:0] hp_dout,
  output logic [DW-1:0] rdata,
  output logic          ready_n,
  output logic          tmo_err,
  output logic          start_evt,
  output logic          rdy_evt,
  output logic          tmo_evt
);
  import lhb_pkg::*;

  localparam int CW = $clog2(TIMEOUT + 1);

  xfer_state_e   state;
  logic [CW-1:0] cnt;
  logic          wr_q;
  logic [DW-1:0] wdata_q;

  function automatic logic last_wait(input logic [CW-1:0] c);
    return c == CW'(TIMEOUT - 1);
  endfunction

  assign start_evt = (state == XS_IDLE) && granted && !ads_n;
  assign rdy_evt   = (state == XS_STRB) && hp_rdy;
  assign tmo_evt   = (state == XS_STRB) && !hp_rdy && last_wait(cnt);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= XS_IDLE;
      cnt     <= '0;
      addr_q  <= '0;
      wr_q    <= 1'b0;
      wdata_q <= '0;
      rdata   <= '0;
      tmo_err <= 1'b0;
    end else begin
      case (state)
        XS_IDLE: if (start_evt) begin
          addr_q <= addr;
          wr_q   <= wr;
          state  <= XS_CAPT;
        end
        XS_CAPT: begin
          wdata_q <= wdata;
          cnt     <= '0;
          state   <= hit ? XS_STRB : XS_DONE;
        end
        XS_STRB: begin
          if (rdy_evt) begin
            rdata <= hp_din;
            state <= XS_DONE;
          end else if (tmo_evt) begin
            rdata   <= '0;
            tmo_err <= 1'b1;
            state   <= XS_DONE;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        default: state <= XS_IDLE;
      endcase
    end
  end

  assign hp_cs_n     = !(hit && (state == XS_CAPT || state == XS_STRB));
  assign hp_strobe_n = (state != XS_STRB);
  assign ready_n     = (state != XS_DONE);
  assign hp_rnw      = !wr_q;
  assign hp_dout     = wdata_q;

endmodule

// File: rtl/lb_hpi_bridge.sv
module lb_hpi_bridge #(
  parameter int          AW          = 16,
  parameter int          DW          = 32,
  parameter int          TIMEOUT     = 8,
  parameter int          REGION_LSB  = 12,
  parameter logic [15:0] REGION_BASE = 16'hA000
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          lb_hold_req,
  output logic          lb_hold_ack,
  output logic          dsp_own_req,
  input  logic          dsp_own_ack,
  input  logic          lb_ads_n,
  input  logic [AW-1:0] lb_addr,
  input  logic          lb_wr,
  input  logic [DW-1:0] lb_wdata,
  output logic [DW-1:0] lb_rdata,
  output logic          lb_ready_n,
  output logic          lb_int_n,
  output logic          hp_cs_n,
  output logic          hp_strobe_n,
  output logic          hp_rnw,
  output logic          hp_hwsel,
  output logic [1:0]    hp_regsel,
  output logic [DW-1:0] hp_dout,
  input  logic [DW-1:0] hp_din,
  input  logic          hp_rdy,
  input  logic          hp_int_n,
  output logic          tmo_err
);

  logic             grant_evt;
  logic             start_evt;
  logic             rdy_evt;
  logic             tmo_evt;
  logic             addr_hit;
  logic [AW-1:0]    addr_q;
  lhb_pkg::hp_sel_t sel;

  lhb_hold_arb u_arb (
    .clk         (clk),
    .rst_n       (rst_n),
    .lb_hold_req (lb_hold_req),
    .dsp_own_ack (dsp_own_ack),
    .dsp_own_req (dsp_own_req),
    .lb_hold_ack (lb_hold_ack),
    .grant_evt   (grant_evt)
  );

  lhb_decode #(.AW(AW), .REGION_LSB(REGION_LSB), .REGION_BASE(REGION_BASE)) u_dec (
    .addr (addr_q),
    .hit  (addr_hit),
    .sel  (sel)
  );

  lhb_xfer #(.AW(AW), .DW(DW), .TIMEOUT(TIMEOUT)) u_xfer (
    .clk         (clk),
    .rst_n       (rst_n),
    .granted     (lb_hold_ack),
    .ads_n       (lb_ads_n),
    .addr        (lb_addr),
    .wr          (lb_wr),
    .wdata       (lb_wdata),
    .hp_din      (hp_din),
    .hp_rdy      (hp_rdy),
    .hit         (addr_hit),
    .addr_q      (addr_q),
    .hp_cs_n     (hp_cs_n),
    .hp_strobe_n (hp_strobe_n),
    .hp_rnw      (hp_rnw),
    .hp_dout     (hp_dout),
    .rdata       (lb_rdata),
    .ready_n     (lb_ready_n),
    .tmo_err     (tmo_err),
    .start_evt   (start_evt),
    .rdy_evt     (rdy_evt),
    .tmo_evt     (tmo_evt)
  );

  assign hp_hwsel  = sel.hwsel;
  assign hp_regsel = sel.regsel;
  assign lb_int_n  = hp_int_n;

endmodule

// File: rtl/lhb_chk.sv
module lhb_chk #(
  parameter int TIMEOUT = 8
) (
  input logic clk,
  input logic rst_n,
  input logic lb_hold_req,
  input logic lb_hold_ack,
  input logic dsp_own_req,
  input logic dsp_own_ack,
  input logic hp_cs_n,
  input logic hp_strobe_n,
  input logic lb_ready_n,
  input logic start_evt,
  input logic rdy_evt,
  input logic tmo_evt
);

  localparam int CW = $clog2(TIMEOUT + 2);
  logic [CW-1:0] strb_run;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) strb_run <= '0;
    else if (hp_strobe_n) strb_run <= '0;
    else if (strb_run != '1) strb_run <= strb_run + 1'b1;
  end

  // R1
  host_priority_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lb_hold_req && dsp_own_req |=> !dsp_own_req);

  // R2
  grant_after_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(lb_hold_ack) |-> $past(lb_hold_req && !dsp_own_req && !dsp_own_ack));

  // R3
  release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !lb_hold_req |=> !lb_hold_ack && dsp_own_req);

  // R5
  start_needs_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start_evt |-> lb_hold_ack);

  // R7
  strobe_in_select_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !hp_strobe_n |-> !hp_cs_n);

  // R9
  ready_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !lb_ready_n |=> lb_ready_n);

  // R9
  ready_follows_rdy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rdy_evt |=> !lb_ready_n && hp_strobe_n);

  // R10
  strobe_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !hp_strobe_n |-> strb_run < CW'(TIMEOUT));

  // R10
  timeout_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tmo_evt |=> !lb_ready_n);

endmodule

bind lb_hpi_bridge lhb_chk #(.TIMEOUT(TIMEOUT)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .lb_hold_req (lb_hold_req),
  .lb_hold_ack (lb_hold_ack),
  .dsp_own_req (dsp_own_req),
  .dsp_own_ack (dsp_own_ack),
  .hp_cs_n     (hp_cs_n),
  .hp_strobe_n (hp_strobe_n),
  .lb_ready_n  (lb_ready_n),
  .start_evt   (start_evt),
  .rdy_evt     (rdy_evt),
  .tmo_evt     (tmo_evt)
);

// File: tb/tb_lb_hpi_bridge.sv
`timescale 1ns/1ps
module tb_lb_hpi_bridge;

  localparam int T = 8;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        lb_hold_req = 1'b0;
  logic        lb_hold_ack;
  logic        dsp_own_req;
  logic        dsp_own_ack = 1'b0;
  logic        lb_ads_n = 1'b1;
  logic [15:0] lb_addr = '0;
  logic        lb_wr = 1'b0;
  logic [31:0] lb_wdata = '0;
  logic [31:0] lb_rdata;
  logic        lb_ready_n;
  logic        lb_int_n;
  logic        hp_cs_n;
  logic        hp_strobe_n;
  logic        hp_rnw;
  logic        hp_hwsel;
  logic [1:0]  hp_regsel;
  logic [31:0] hp_dout;
  logic [31:0] hp_din = '0;
  logic        hp_rdy = 1'b0;
  logic        hp_int_n = 1'b1;
  logic        tmo_err;

  int  checks = 0;
  int  fails = 0;
  bit  dsp_busy = 1'b0;
  bit  err_exp = 1'b0;
  bit  done = 1'b0;

  always #2.5 clk = ~clk;

  // DSP model: acknowledges ownership one clock after it is offered
  always @(posedge clk) dsp_own_ack <= dsp_own_req && dsp_busy;

  lb_hpi_bridge dut (
    .clk(clk), .rst_n(rst_n), .lb_hold_req(lb_hold_req), .lb_hold_ack(lb_hold_ack),
    .dsp_own_req(dsp_own_req), .dsp_own_ack(dsp_own_ack), .lb_ads_n(lb_ads_n),
    .lb_addr(lb_addr), .lb_wr(lb_wr), .lb_wdata(lb_wdata), .lb_rdata(lb_rdata),
    .lb_ready_n(lb_ready_n), .lb_int_n(lb_int_n), .hp_cs_n(hp_cs_n),
    .hp_strobe_n(hp_strobe_n), .hp_rnw(hp_rnw), .hp_hwsel(hp_hwsel),
    .hp_regsel(hp_regsel), .hp_dout(hp_dout), .hp_din(hp_din), .hp_rdy(hp_rdy),
    .hp_int_n(hp_int_n), .tmo_err(tmo_err)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic summary();
    if (!done) begin
      done = 1'b1;
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    end
  endtask

  // hold handshake; busy selects whether the DSP model is using the bus
  task automatic t_grant(input bit busy);
    int n;
    dsp_busy = busy;
    repeat (3) @(negedge clk);
    lb_hold_req = 1'b1;
    @(negedge clk);
    chk("R1 own req withdrawn", dsp_own_req, 1'b0);
    n = 1;
    while (!lb_hold_ack && n < 10) begin
      @(negedge clk);
      n++;
    end
    // idle DSP: grant after 2 edges; busy DSP: 3 edges (ack drains one clock later)
    chk("R2 grant latency", n, busy ? 3 : 2);
    chk("R2 dsp ack low at grant", dsp_own_ack, 1'b0);
  endtask

  task automatic t_release();
    @(negedge clk);
    lb_hold_req = 1'b0;
    @(negedge clk);
    chk("R3 hold ack cleared", lb_hold_ack, 1'b0);
    chk("R3 own req restored", dsp_own_req, 1'b1);
  endtask

  // lat < 0: host port never ready
  task automatic t_access(input logic [15:0] a, input bit w, input logic [31:0] wd,
                          input int lat, input logic [31:0] rd);
    bit hit;
    int scnt;
    int got_at;
    int exp_s;
    bit tmo;
    hit = (a[15:12] == 4'hA);
    tmo = hit && (lat < 0 || lat >= T);
    exp_s = !hit ? 0 : (tmo ? T : lat + 1);
    @(negedge clk);
    lb_ads_n = 1'b0; lb_addr = a; lb_wr = w;
    @(negedge clk);
    lb_ads_n = 1'b1; lb_wdata = wd; hp_din = rd; lb_addr = ~a; lb_wr = ~w;
    chk("R7 select after strobe cycle", hp_cs_n, !hit);
    scnt = 0;
    got_at = -1;
    for (int i = 0; i < 40 && got_at < 0; i++) begin
      @(negedge clk);
      if (!lb_ready_n) got_at = i;
      else if (!hp_strobe_n) begin
        scnt++;
        if (scnt == 1) begin
          chk("R7 select during strobe", hp_cs_n, 1'b0);
          chk("R8 half-word select", hp_hwsel, a[2]);
          chk("R8 register select", hp_regsel, a[4:3]);
          chk("R6 direction", hp_rnw, !w);
          if (w) chk("R6 write data", hp_dout, wd);
        end
        if (lat >= 0 && scnt == lat + 1) hp_rdy = 1'b1;
      end
      if (!hit) chk("R7 no select outside region", hp_cs_n, 1'b1);
    end
    if (!hit) chk("R12 ready after one wait state", got_at, 0);
    else chk(tmo ? "R10 strobe length at timeout" : "R9 strobe length", scnt, exp_s);
    chk("R9 ready returned", got_at >= 0, 1'b1);
    if (hit && !w) chk(tmo ? "R10 read data zero" : "R11 read data", lb_rdata, tmo ? 32'h0 : rd);
    if (tmo) err_exp = 1'b1;
    chk("R10 timeout flag", tmo_err, err_exp);
    hp_rdy = 1'b0;
    @(negedge clk);
    chk("R9 ready single cycle", lb_ready_n, 1'b1);
  endtask

  task automatic t_no_grant();
    bit seen;
    seen = 1'b0;
    @(negedge clk);
    lb_ads_n = 1'b0; lb_addr = 16'hA010; lb_wr = 1'b1;
    @(negedge clk);
    lb_ads_n = 1'b1;
    for (int i = 0; i < 5; i++) begin
      if (!hp_cs_n || !lb_ready_n) seen = 1'b1;
      @(negedge clk);
    end
    chk("R5 strobe ignored without grant", seen, 1'b0);
  endtask

  task automatic t_irq();
    hp_int_n = 1'b0;
    #1;
    chk("R13 interrupt low", lb_int_n, 1'b0);
    hp_int_n = 1'b1;
    #1;
    chk("R13 interrupt high", lb_int_n, 1'b1);
  endtask

  initial begin
    #(5.0 * 100000);
    fails++;
    $display("FAIL watchdog expired");
    summary();
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R4 hold ack", lb_hold_ack, 1'b0);
    chk("R4 own req", dsp_own_req, 1'b1);
    chk("R4 select", hp_cs_n, 1'b1);
    chk("R4 strobe", hp_strobe_n, 1'b1);
    chk("R4 ready", lb_ready_n, 1'b1);
    chk("R4 timeout flag", tmo_err, 1'b0);
    rst_n = 1'b1;
    t_no_grant();
    t_grant(1'b0);
    t_access(16'hA01C, 1'b1, 32'hDEADBEEF, 0, 32'h0);
    t_access(16'hA008, 1'b0, 32'h0, 3, 32'h12345678);
    t_access(16'h3014, 1'b1, 32'h5555AAAA, 0, 32'h0);
    t_access(16'hA004, 1'b0, 32'h0, T - 1, 32'hCAFEF00D);
    t_access(16'hA010, 1'b0, 32'h0, -1, 32'hFFFF0000);
    t_access(16'hA014, 1'b0, 32'h0, 1, 32'h0BADC0DE);
    t_release();
    t_no_grant();
    t_grant(1'b1);
    t_access(16'hAFF8, 1'b1, 32'h01020304, 2, 32'h0);
    t_release();
    t_irq();
    summary();
    $finish;
  end

endmodule